// File: doc/BRIEF.md
# Galloping-Pattern Memory Read Tester

This block walks a small read-only memory through one of two read sequences and checks every enabled read against a checkerboard that it computes on the fly. The memory sits outside the block. The tester drives an address and an active-low enable, takes the returned data, and at the end of a pass reports pass or fail. On failure it also reports the address and the data of the first word that read back wrong.

In galloping mode every word acts as a base in turn. The tester reads the base word and then a partner word, stepping the partner from the base itself up to the top word. It then moves on to the next base. This exercises address transitions between every pair of words, and a pass lasts N·(N+1) clocks. In sequential mode each word gets two clocks: one with the enable off and one with it on. This exercises the enable-to-output path, and a pass lasts 2·N clocks.

A start pulse is accepted only while the tester is idle, and the mode input is sampled at that moment.

Top module: `gallop_read_tester`

## Requirements
- R1: After reset, busy, done and pass are 0, fail_addr and fail_data are 0, and mem_en_n is 1.
- R2: start is acted on only while busy is 0, and mode is sampled in that same cycle (0 = galloping, 1 = sequential). A start pulse or a mode change during a pass has no effect on that pass.
- R3: Galloping order: for base b = 0 .. N-1, and for partner w = b .. N-1, the tester reads b and then w, one clock each. mem_en_n stays 0 for the whole pass, so the pass takes N·(N+1) clocks.
- R4: Sequential order: for word a = 0 .. N-1, the tester spends one clock with mem_en_n = 1 and then one clock with mem_en_n = 0, with mem_addr = a in both. The pass takes 2·N clocks.
- R5: The expected data for address a is a checkerboard. Bit j is 1 when a[0] and j[0] are equal, so an even address expects 4'b0101 and an odd address expects 4'b1010 (for DATA_W = 4). Exactly half of all bits are 1.
- R6: rd_data is compared only in cycles where mem_en_n is 0. Wrong data while the enable is off does not fail the pass.
- R7: The first mismatching read sets fail_addr to its address and fail_data to the data that was read. Later mismatches in the same pass do not change them.
- R8: In the clock after the last read, busy falls and done is 1 for exactly one cycle. pass is then 1 if the pass saw no mismatch and 0 otherwise, and pass, fail_addr and fail_data hold until the next accepted start.
- R9: busy is 1 in every cycle from the clock after an accepted start up to and including the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a pass (accepted only while idle) |
| mode | input | 1 | 0 = galloping, 1 = sequential; sampled with start |
| rd_data | input | DATA_W | Data returned by the memory for mem_addr |
| mem_addr | output | ADDR_W | Address presented to the memory |
| mem_en_n | output | 1 | Memory enable, active low |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| pass | output | 1 | Result of the last pass (1 = no mismatch) |
| fail_addr | output | ADDR_W | Address of the first mismatching read |
| fail_data | output | DATA_W | Data observed at the first mismatch |

## Verification
The properties check on every cycle the shape of each pass:
- the enable is never active while idle;
- the enable stays on throughout a galloping pass;
- the enable toggles on every sequential clock while the address holds;
- done is a single-cycle pulse that coincides with busy falling.

Only the bench scenarios can show the full address order of both modes, the pass lengths, and which mismatch is recorded. Those scenarios also show that wrong data with the enable off is ignored and that a start pulse mid-pass is dropped.

// File: rtl/gallop_read_tester.sv
module gallop_read_tester #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_n,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_data
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  function automatic logic [DATA_W-1:0] checker_word(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    for (int j = 0; j < DATA_W; j++) w[j] = (a[0] == j[0]);
    return w;
  endfunction

  logic              running, mode_q, ph, err;
  logic [ADDR_W-1:0] base, upper;
  logic              reading, miss, last;

  assign busy     = running;
  assign reading  = running && (mode_q ? ph : 1'b1);
  assign mem_en_n = ~reading;
  assign mem_addr = (!mode_q && ph) ? upper : base;
  assign miss     = reading && (rd_data != checker_word(mem_addr));
  assign last     = (base == TOP) && (mode_q || upper == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      mode_q    <= 1'b0;
      ph        <= 1'b0;
      err       <= 1'b0;
      base      <= '0;
      upper     <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_addr <= '0;
      fail_data <= '0;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (start) begin
          running   <= 1'b1;
          mode_q    <= mode;
          ph        <= 1'b0;
          err       <= 1'b0;
          base      <= '0;
          upper     <= '0;
          pass      <= 1'b0;
          fail_addr <= '0;
          fail_data <= '0;
        end
      end else begin
        if (miss && !err) begin
          err       <= 1'b1;
          fail_addr <= mem_addr;
          fail_data <= rd_data;
        end
        ph <= ~ph;
        if (ph) begin
          if (last) begin
            running <= 1'b0;
            done    <= 1'b1;
            pass    <= ~(err | miss);
          end else if (mode_q || upper == TOP) begin
            base  <= base + 1'b1;
            upper <= base + 1'b1;
          end else begin
            upper <= upper + 1'b1;
          end
        end
      end
    end
  end
endmodule

module gallop_read_tester_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_en_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mode_q
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mem_en_n);
  // R3
  gallop_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> !mem_en_n);
  // R4
  seq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q && $past(busy)) |-> (mem_en_n != $past(mem_en_n)));
  // R4
  seq_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q && !mem_en_n && $past(busy)) |-> $stable(mem_addr));
endmodule

bind gallop_read_tester gallop_read_tester_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_en_n(mem_en_n), .mem_addr(mem_addr), .mode_q(mode_q)
);

// File: tb/test_gallop_read_tester.sv
module test_gallop_read_tester;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_en_n, busy, done, pass;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_data;

  int checks = 0;
  int errors = 0;

  int          inj_n = 0;
  logic [AW-1:0] inj_a1 = '0, inj_a2 = '0;
  logic [DW-1:0] inj_m1 = '0, inj_m2 = '0;

  always #5 clk = ~clk;

  gallop_read_tester #(.ADDR_W(AW), .DATA_W(DW)) i_gallop_read_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_en_n(mem_en_n), .busy(busy), .done(done),
    .pass(pass), .fail_addr(fail_addr), .fail_data(fail_data)
  );

  function automatic logic [DW-1:0] good_word(input logic [AW-1:0] a);
    return a[0] ? 4'b1010 : 4'b0101;
  endfunction

  always_comb begin
    logic [DW-1:0] v;
    v = good_word(mem_addr);
    if (inj_n > 0 && mem_addr == inj_a1) v = v ^ inj_m1;
    if (inj_n > 1 && mem_addr == inj_a2) v = v ^ inj_m2;
    rd_data = mem_en_n ? ~good_word(mem_addr) : v;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_pass(input bit m, input bit poke);
    int step = 0;
    int bad = 0;
    int ba = 0, be = 0;
    logic [AW-1:0] fa;
    logic [DW-1:0] fd;
    bit exp_ok;
    exp_ok = (inj_n == 0);
    fa = inj_a1; fd = good_word(inj_a1) ^ inj_m1;
    if (inj_n > 1 && inj_a2 < inj_a1) begin fa = inj_a2; fd = good_word(inj_a2) ^ inj_m2; end
    if (exp_ok) begin fa = '0; fd = '0; end
    @(negedge clk); start = 1'b1; mode = m;
    @(negedge clk); start = 1'b0; mode = ~m;
    for (int b = 0; b < N; b++) begin
      for (int w = (m ? b : b); w < (m ? b + 1 : N); w++) begin
        for (int p = 0; p < 2; p++) begin
          int ea;
          logic een;
          ea  = m ? b : (p == 0 ? b : w);
          een = m ? (p == 0) : 1'b0;
          if (bad == 0 && (!busy || mem_addr != ea[AW-1:0] || mem_en_n != een)) begin
            bad = 1; ba = {busy, mem_en_n, mem_addr}; be = {1'b1, een, ea[AW-1:0]};
          end
          if (poke && step == 5) start = 1'b1;
          if (poke && step == 6) start = 1'b0;
          step++;
          @(negedge clk);
        end
      end
    end
    start = 1'b0;
    if (m) chk(bad == 0, "R4", "sequential order {busy,en_n,addr}", ba, be);
    else   chk(bad == 0, "R3", "galloping order {busy,en_n,addr}", ba, be);
    if (poke) chk(bad == 0, "R2", "start during pass ignored", ba, be);
    chk(step == (m ? 2 * N : N * (N + 1)), "R9", "busy cycles", step, m ? 2 * N : N * (N + 1));
    chk(done == 1'b1 && busy == 1'b0, "R8", "done/busy at end", {done, busy}, 2);
    chk(pass == exp_ok, exp_ok ? "R5" : "R7", "pass flag", pass, exp_ok);
    chk(fail_addr == fa, "R7", "fail_addr", fail_addr, fa);
    chk(fail_data == fd, "R7", "fail_data", fail_data, fd);
    @(negedge clk);
    chk(done == 1'b0 && pass == exp_ok, "R8", "done pulse ends, pass held", {done, pass}, {1'b0, exp_ok});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && pass == 0 && fail_addr == 0 && fail_data == 0 && mem_en_n == 1,
        "R1", "reset state", {busy, done, pass, mem_en_n}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);

    inj_n = 0; run_pass(1'b0, 1'b0);                 // R5 clean galloping
    inj_n = 0; run_pass(1'b1, 1'b0);                 // R6 seq: disabled data is wrong, still passes
    chk(pass == 1'b1, "R6", "disabled reads ignored", pass, 1);
    inj_n = 1; inj_a1 = '0; inj_m1 = 4'h1; run_pass(1'b0, 1'b0);
    inj_n = 1; inj_a1 = AW'(N - 1); inj_m1 = 4'hF; run_pass(1'b0, 1'b0);
    inj_n = 1; inj_a1 = AW'(N - 1); inj_m1 = 4'h8; run_pass(1'b1, 1'b0);
    inj_n = 2; inj_a1 = AW'(9); inj_m1 = 4'h2; inj_a2 = AW'(3); inj_m2 = 4'h4; run_pass(1'b0, 1'b0);
    inj_n = 0; run_pass(1'b0, 1'b1);                 // R2 poke
    inj_n = 2; inj_a1 = AW'(2); inj_m1 = 4'h3; inj_a2 = AW'(7); inj_m2 = 4'hC; run_pass(1'b1, 1'b1);

    for (int i = 0; i < 14; i++) begin
      logic [DW-1:0] m1, m2;
      inj_n  = $urandom_range(0, 2);
      inj_a1 = AW'($urandom_range(0, N - 1));
      inj_a2 = AW'($urandom_range(0, N - 1));
      if (inj_a2 == inj_a1) inj_a2 = inj_a1 + 1'b1;
      m1 = DW'($urandom_range(1, 15)); m2 = DW'($urandom_range(1, 15));
      inj_m1 = m1; inj_m2 = m2;
      run_pass(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule